// File: doc/BRIEF.md
# Input Period Measurement Timer

This block is one channel of a general-purpose timer, set up to measure how long an input signal takes to repeat. It watches an asynchronous input pin and picks out edges of one polarity. Control inputs select rising or falling edges. The first such edge arms the channel. On the next timer tick the counter is preset from a programmable start value, and it then advances by one on every tick. Ticks arrive as a one-cycle enable and stand for the system clock divided by two or a prescaler output.

The next edge of the same polarity copies the running count into a capture register and raises a sticky compare flag. With the retrigger control set, that same edge starts the next measurement, so back-to-back periods are all measured. With it clear, the counter keeps running and later edges capture the growing total. When the counter passes its all-ones value it sets a sticky overflow flag. Each flag drives its own interrupt request, gated by its enable.

Top module: `period_timer`

## Requirements
- R1: After reset the capture register reads 0 and both flags and both interrupt requests are 0.
- R2: While `en` is 0 the counter is held at 0, and input edges change neither the capture register nor the compare flag. After `en` returns to 1, the first selected edge only arms the channel.
- R3: With `inv` = 0 only 0-to-1 transitions of `pin_in` are selected. With `inv` = 1 only 1-to-0 transitions are selected. Transitions of the other polarity have no effect.
- R4: `pin_in` passes through two synchronizing flops and is compared with one further delayed sample. A transition first sampled at clock edge k takes effect at clock edge k+2.
- R5: After the arming edge, the counter loads `load_val` on the first clock edge with `tick` = 1 that comes strictly later. It then adds 1 at each clock edge with `tick` = 1 and holds otherwise.
- R6: The next selected edge after the load copies the counter into `capture` and sets `cmp_flag`. A selected edge that comes before the load tick is ignored.
- R7: With `retrig` = 1, the capturing edge also arms the next measurement. The counter reloads `load_val` on the next tick and does not advance on the capturing edge itself.
- R8: With `retrig` = 0, the counter keeps advancing after a capture, and each later selected edge captures the running count without a reload.
- R9: A tick while the running counter is all ones wraps the counter to 0 and sets `ovf_flag`.
- R10: Each flag stays set until a cycle with its clear strobe at 1. A new set event in the same cycle as a clear wins.
- R11: `cmp_irq` is `cmp_flag` AND `cmp_ie`. `ovf_irq` is `ovf_flag` AND `ovf_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Timer clock enable, one cycle per timer tick |
| pin_in | input | 1 | Asynchronous input whose period is measured |
| en | input | 1 | Channel enable; low clears and stops the counter |
| inv | input | 1 | 0 selects rising edges, 1 selects falling edges |
| retrig | input | 1 | 1 restarts from `load_val` after each capture |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| load_val | input | W | Counter start value |
| cmp_clr | input | 1 | Clear strobe for the compare flag |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| capture | output | W | Count captured at the last measuring edge |
| cmp_flag | output | 1 | Sticky capture-done flag |
| ovf_flag | output | 1 | Sticky counter-overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The hardest situation to reach is a selected edge that lands while the channel is armed but has not yet seen its load tick. Only then is an edge meant to be dropped. The stimulus holds `tick` at 0 across an arming edge and a second edge, then turns ticks back on. The next capture must count from the first arming edge. The overflow wrap would take millions of ticks from a small start value, so a start value a few counts below all ones brings it within reach. Random tick patterns are logged cycle by cycle, and each expected capture is worked out from that log.

// File: rtl/period_timer.sv
module period_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pin_in,
  input  logic         en,
  input  logic         inv,
  input  logic         retrig,
  input  logic         cmp_ie,
  input  logic         ovf_ie,
  input  logic [W-1:0] load_val,
  input  logic         cmp_clr,
  input  logic         ovf_clr,
  output logic [W-1:0] capture,
  output logic         cmp_flag,
  output logic         ovf_flag,
  output logic         cmp_irq,
  output logic         ovf_irq
);
  typedef enum logic [1:0] {IDLE, ARMWAIT, PRELOAD, RUN} st_t;

  st_t          st;
  logic [W-1:0] cnt;
  logic [2:0]   smp;
  logic         hit, grab, wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) smp <= '0;
    else        smp <= {smp[1:0], pin_in};

  assign hit  = en && (inv ? (smp[2] && !smp[1]) : (!smp[2] && smp[1]));
  assign grab = (st == RUN) && hit;
  assign wrap = (st == RUN) && tick && (&cnt) && !(grab && retrig);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
    end else if (!en) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE, ARMWAIT: st <= hit ? PRELOAD : ARMWAIT;
        PRELOAD: if (tick) begin
          cnt <= load_val;
          st  <= RUN;
        end
        default: begin
          if (grab && retrig) st <= PRELOAD;
          else if (tick)      cnt <= cnt + 1'b1;
        end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      capture  <= '0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (grab) capture <= cnt;
      cmp_flag <= grab || (cmp_flag && !cmp_clr);
      ovf_flag <= wrap || (ovf_flag && !ovf_clr);
    end

  assign cmp_irq = cmp_flag && cmp_ie;
  assign ovf_irq = ovf_flag && ovf_ie;
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         en,
  input logic [W-1:0] load_val,
  input logic         cmp_clr,
  input logic         ovf_clr,
  input logic [W-1:0] capture,
  input logic         cmp_flag,
  input logic         ovf_flag,
  input logic [1:0]   st,
  input logic [W-1:0] cnt
);
  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(capture));

  a_r5_preload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == 2'd2 && tick) |=> (cnt == $past(load_val)));

  a_r6_capture_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capture) |-> cmp_flag);

  a_r9_wrap_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt) == {W{1'b1}}));

  a_r10_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !cmp_clr) |=> cmp_flag);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind period_timer period_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .load_val(load_val),
  .cmp_clr(cmp_clr), .ovf_clr(ovf_clr), .capture(capture),
  .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .st(st), .cnt(cnt)
);

// File: tb/tb_period_timer.sv
`timescale 1ns/1ps
module tb_period_timer;
  localparam int W = 24;
  localparam int LOGN = 4096;

  logic clk = 0, rst_n = 0, tick = 0, pin_in = 0, en = 0, inv = 0, retrig = 0;
  logic cmp_ie = 0, ovf_ie = 0, cmp_clr = 0, ovf_clr = 0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] capture;
  logic cmp_flag, ovf_flag, cmp_irq, ovf_irq;

  period_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in), .en(en), .inv(inv),
    .retrig(retrig), .cmp_ie(cmp_ie), .ovf_ie(ovf_ie), .load_val(load_val),
    .cmp_clr(cmp_clr), .ovf_clr(ovf_clr), .capture(capture), .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq));

  always #2.5 clk = ~clk;

  int  cyc = 0, checks = 0, fails = 0, tmode = 0;
  bit  tlog [0:LOGN-1];

  always @(posedge clk) begin
    if (cyc < LOGN) tlog[cyc] = tick;
    cyc = cyc + 1;
  end

  always @(negedge clk)
    case (tmode)
      0:       tick <= 1'b1;
      1:       tick <= (cyc % 4 == 0) || ($urandom_range(0, 2) != 0);
      default: tick <= 1'b0;
    endcase

  function automatic logic [W-1:0] exp_cap(input logic [W-1:0] lv, input int a, input int b);
    int t = a + 1;
    int n = 0;
    while (t < b && !tlog[t]) t++;
    for (int k = t + 1; k < b; k++) n += tlog[k];
    return lv + W'(n);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_pin(input logic v, output int act);
    @(negedge clk);
    pin_in = v;
    act = cyc + 2;
  endtask

  task automatic wait_after(input int b);
    while (cyc <= b) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); cmp_clr = 1; ovf_clr = 1;
    @(negedge clk); cmp_clr = 0; ovf_clr = 0;
  endtask

  task automatic restart();
    @(negedge clk); en = 0;
    idle(3);
    en = 1;
    idle(2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int a, b, x, e;
    logic [W-1:0] lv;
    void'($urandom(32'd7));
    idle(4);
    @(negedge clk); rst_n = 1;
    idle(1);
    // R1 reset state
    check("R1 capture", capture, 0);
    check("R1 flags", {cmp_flag, ovf_flag}, 0);
    check("R1 irqs", {cmp_irq, ovf_irq}, 0);

    // Rising edges, ticks every cycle, retrigger on
    lv = 24'd100; load_val = lv; retrig = 1; cmp_ie = 1; tmode = 0;
    restart();
    set_pin(1, a); idle(5); set_pin(0, x); idle(8); set_pin(1, b);
    while (cyc < b) @(negedge clk);
    check("R4 flag before act edge", cmp_flag, 0);
    wait_after(b);
    check("R4 flag at act edge", cmp_flag, 1);
    check("R5 capture directed", capture, 24'(lv + W'(b - a - 2)));
    check("R6 capture", capture, exp_cap(lv, a, b));
    check("R11 cmp_irq on", cmp_irq, 1);
    idle(4); set_pin(0, x); idle(12); set_pin(1, e); wait_after(e);
    check("R7 retrigger capture", capture, exp_cap(lv, b, e));

    // Interrupt gating and flag clear
    cmp_ie = 0; idle(1);
    check("R11 cmp_irq gated", cmp_irq, 0);
    check("R10 flag held", cmp_flag, 1);
    clear_flags();
    check("R10 flag cleared", cmp_flag, 0);

    // Falling edges selected
    @(negedge clk); en = 0; inv = 1; pin_in = 1; idle(4);
    en = 1; lv = 24'd5000; load_val = lv; idle(2);
    set_pin(0, a); idle(7); set_pin(1, x); wait_after(x); idle(2);
    check("R3 rising ignored when inv", cmp_flag, 0);
    idle(6); set_pin(0, b); wait_after(b);
    check("R3 falling capture", capture, exp_cap(lv, a, b));
    idle(3); clear_flags();

    // Non-retrigger, random ticks
    @(negedge clk); en = 0; inv = 0; pin_in = 0; retrig = 0; tmode = 1;
    lv = W'($urandom()); load_val = lv; idle(3); en = 1; idle(2);
    set_pin(1, a); idle(4); set_pin(0, x);
    for (int i = 0; i < 4; i++) begin
      idle($urandom_range(9, 30)); set_pin(1, b); wait_after(b);
      check("R8 running capture", capture, exp_cap(lv, a, b));
      idle(3); set_pin(0, x);
    end

    // Retrigger, random ticks and random periods
    retrig = 1; lv = W'($urandom_range(0, 60000)); load_val = lv;
    restart();
    set_pin(1, a); idle(3); set_pin(0, x);
    for (int i = 0; i < 12; i++) begin
      idle($urandom_range(9, 35)); set_pin(1, b); wait_after(b);
      check("R7 back-to-back period", capture, exp_cap(lv, a, b));
      a = b;
      idle($urandom_range(2, 6)); set_pin(0, x);
    end
    clear_flags();

    // Overflow near all ones
    tmode = 0; ovf_ie = 0; lv = 24'hFFFFFB; load_val = lv;
    restart(); clear_flags();
    set_pin(1, a); idle(5); set_pin(0, x); idle(12); set_pin(1, b); wait_after(b);
    check("R9 wrapped capture", capture, 24'(lv + W'(b - a - 2)));
    check("R9 ovf flag", ovf_flag, 1);
    check("R11 ovf_irq gated", ovf_irq, 0);
    ovf_ie = 1; idle(1);
    check("R11 ovf_irq on", ovf_irq, 1);
    clear_flags();
    check("R10 ovf cleared", ovf_flag, ovf_flag & 1'b0);
    ovf_ie = 0; idle(3); set_pin(0, x);

    // Edge before the load tick is dropped
    lv = 24'd300; load_val = lv;
    restart(); tmode = 2; idle(2); clear_flags();
    set_pin(1, a); idle(3); set_pin(0, x); idle(3); set_pin(1, e); wait_after(e); idle(2);
    check("R6 edge before load ignored", cmp_flag, 0);
    tmode = 0; idle(4); set_pin(0, x); idle(9); set_pin(1, b); wait_after(b);
    check("R6 capture after dropped edge", capture, exp_cap(lv, a, b));
    clear_flags();

    // Disabled channel ignores edges, re-enable needs arming edge
    @(negedge clk); en = 0; lv = capture; idle(2);
    for (int i = 0; i < 3; i++) begin
      set_pin(0, x); idle(4); set_pin(1, x); wait_after(x); idle(2);
    end
    check("R2 capture held while disabled", capture, lv);
    check("R2 no flag while disabled", cmp_flag, 0);
    set_pin(0, x); idle(3); en = 1; load_val = 24'd40; idle(2);
    set_pin(1, a); wait_after(a); idle(3);
    check("R2 first edge only arms", cmp_flag, 0);
    set_pin(0, x); idle(8); set_pin(1, b); wait_after(b);
    check("R2 capture after re-enable", capture, exp_cap(24'd40, a, b));

    idle(3);
    summary();
    $finish;
  end
endmodule